// File: doc/BRIEF.md
# Coefficient Boot Loader from Byte-Wide ROM

This block fills a filter's coefficient store from an external byte-wide ROM without help from a host. A single-cycle start request launches the transfer: the loader drives the ROM address lines itself and reads back 128 consecutive bytes. It joins each pair of bytes into one 16-bit coefficient and writes the 64 coefficients, in ascending order, through a simple write port. A busy output stays high from the cycle after the start is taken until one cycle after the last coefficient write.

A 4-bit device number forms the upper ROM address bits, so one ROM holds sixteen 128-byte regions. Up to sixteen filter devices can therefore boot from the same part. A wait count, latched at start, stretches every byte read so that slow ROMs have time to settle before the byte is taken.

Top module: `coef_boot_loader`

## Requirements
- R1: After reset, `busy` and `cw_en` are low and `rom_addr` is zero.
- R2: A high `start` seen at a clock edge while `busy` is low raises `busy` after that edge. `busy` then stays high for exactly 128*(W+1)+1 cycles, where W is the latched wait count.
- R3: During a transfer, `rom_addr[10:7]` equals the device number latched at start. `rom_addr[6:0]` is the byte index, which steps from 0 to 127 by one.
- R4: Each byte address is held for W+1 cycles, and the byte is sampled on the (W+1)-th edge after the address appears. Coefficient j is written in the cycle after edge (2j+2)*(W+1), counted from the start edge.
- R5: Coefficient j is {byte 2j+1, byte 2j}, so the even byte is the low half. It is written at `cw_addr` = j, with j running 0..63 in order. Each write is a one-cycle `cw_en` pulse, and a transfer makes exactly 64 writes.
- R6: `busy` falls in the cycle right after the cycle in which coefficient 63 is written.
- R7: While `busy` is high, `start` has no effect, and changes on `dev_sel` or `wait_cycles` have no effect on addresses, timing or data.
- R8: `cw_en` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load request, taken only while idle |
| dev_sel | input | 4 | Device number selecting the ROM region |
| wait_cycles | input | 4 | Extra cycles each byte address is held before sampling |
| rom_addr | output | 11 | ROM address {device, byte index} |
| rom_data | input | 8 | ROM data byte |
| busy | output | 1 | High for the whole transfer |
| cw_en | output | 1 | Coefficient write strobe |
| cw_addr | output | 6 | Coefficient index being written |
| cw_data | output | 16 | Coefficient value |

## Verification
The hardest case to reach from the ports is a transfer that changes its own parameters partway through. A second start request, a new device number and a new wait count all arrive while the first load is still running. The bench injects these at a random cycle inside several transfers. Its ROM model returns inverted data whenever an address has been stable for fewer than the latched wait count. As a result, any use of the new wait count, or any off-by-one in the sampling point, corrupts coefficients that the bench then compares.

// File: rtl/coef_boot_loader.sv
module coef_boot_loader #(
  parameter int DEV_W  = 4,
  parameter int COEF_N = 64,
  parameter int COEF_W = 16,
  parameter int WAIT_W = 4,
  localparam int BYTE_W = COEF_W / 2,
  localparam int BYTE_N = 2 * COEF_N,
  localparam int IDX_W  = $clog2(BYTE_N),
  localparam int CA_W   = $clog2(COEF_N),
  localparam int ADDR_W = DEV_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DEV_W-1:0]  dev_sel,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0] rom_data,
  output logic              busy,
  output logic              cw_en,
  output logic [CA_W-1:0]   cw_addr,
  output logic [COEF_W-1:0] cw_data
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_LAST} state_t;

  state_t              state;
  logic [DEV_W-1:0]    dev_q;
  logic [WAIT_W-1:0]   wait_q;
  logic [WAIT_W-1:0]   cnt;
  logic [IDX_W-1:0]    idx;
  logic [BYTE_W-1:0]   lo_q;

  wire take = (state == S_READ) && (cnt == wait_q);
  wire last = (idx == IDX_W'(BYTE_N - 1));

  assign busy     = (state != S_IDLE);
  assign rom_addr = {dev_q, idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      dev_q   <= '0;
      wait_q  <= '0;
      cnt     <= '0;
      idx     <= '0;
      lo_q    <= '0;
      cw_en   <= 1'b0;
      cw_addr <= '0;
      cw_data <= '0;
    end else begin
      cw_en <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state  <= S_READ;
          dev_q  <= dev_sel;
          wait_q <= wait_cycles;
          idx    <= '0;
          cnt    <= '0;
        end
        S_READ: if (take) begin
          cnt <= '0;
          if (!idx[0]) lo_q <= rom_data;
          else begin
            cw_en   <= 1'b1;
            cw_addr <= idx[IDX_W-1:1];
            cw_data <= {rom_data, lo_q};
          end
          if (last) state <= S_LAST;
          else      idx   <= idx + IDX_W'(1);
        end else begin
          cnt <= cnt + WAIT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/coef_boot_loader_chk.sv
module coef_boot_loader_chk #(
  parameter int ADDR_W = 11,
  parameter int IDX_W  = 7,
  parameter int CA_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              cw_en,
  input logic [CA_W-1:0]   cw_addr,
  input logic [ADDR_W-1:0] rom_addr
);

  logic [CA_W:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) wr_cnt <= '0;
    else if (cw_en)      wr_cnt <= wr_cnt + 1'b1;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && rom_addr != $past(rom_addr)) |->
      (rom_addr[IDX_W-1:0] == $past(rom_addr[IDX_W-1:0]) + 1'b1));

  p_wr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |-> (cw_addr == wr_cnt[CA_W-1:0]));

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cw_en) && $past(cw_addr) == {CA_W{1'b1}}));

  p_dev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rom_addr[ADDR_W-1:IDX_W]));

  p_wr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |-> busy);

endmodule

bind coef_boot_loader coef_boot_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .cw_en(cw_en), .cw_addr(cw_addr), .rom_addr(rom_addr)
);

// File: tb/test_coef_boot_loader.sv
`timescale 1ns/1ps
module test_coef_boot_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  dev_sel = '0;
  logic [3:0]  wait_cycles = '0;
  logic [10:0] rom_addr;
  logic [7:0]  rom_data;
  logic        busy, cw_en;
  logic [5:0]  cw_addr;
  logic [15:0] cw_data;

  int errors = 0, checks = 0, cyc = 0;
  int acc = 0, age = 0;
  logic [10:0] last_addr = '0;
  logic mon_on = 1'b0;
  int exp_j, exp_w, c0, last_wr;
  logic [3:0] exp_dev;

  always #10 clk = ~clk;

  coef_boot_loader i_coef_boot_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel),
    .wait_cycles(wait_cycles), .rom_addr(rom_addr), .rom_data(rom_data),
    .busy(busy), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data)
  );

  function automatic logic [7:0] rom_b(input logic [10:0] a);
    int v;
    v = int'(a) * 37 ^ (int'(a) >> 3) * 11 ^ 32'hA5;
    return v[7:0];
  endfunction

  function automatic logic [15:0] exp_coef(input logic [3:0] d, input int j);
    logic [6:0] lo_i, hi_i;
    lo_i = 7'(2 * j);
    hi_i = 7'(2 * j + 1);
    return {rom_b({d, hi_i}), rom_b({d, lo_i})};
  endfunction

  // ROM with access time: inverted data until the address has settled acc cycles
  assign rom_data = (age >= acc) ? rom_b(rom_addr) : ~rom_b(rom_addr);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rom_addr != last_addr) age <= 0;
    else if (age < 1000) age <= age + 1;
    last_addr <= rom_addr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !busy && cw_en) chk(1'b0, "R8", "write while idle", 1, 0);
    if (mon_on && busy) begin
      chk(rom_addr[10:7] == exp_dev, "R3", "device bits", rom_addr[10:7], exp_dev);
      if (cw_en) begin
        chk(cw_addr == 6'(exp_j), "R5", "coef index", cw_addr, exp_j);
        chk(cw_data == exp_coef(exp_dev, exp_j), "R5", "coef data",
            cw_data, exp_coef(exp_dev, exp_j));
        chk(cyc - c0 == (2 * exp_j + 2) * (exp_w + 1), "R4", "write cycle",
            cyc - c0, (2 * exp_j + 2) * (exp_w + 1));
        last_wr = cyc;
        exp_j++;
      end
    end
  end

  task automatic run_load(input logic [3:0] d, input int w, input bit inject, input int inj_at);
    int n;
    @(negedge clk);
    acc = w;
    dev_sel = d;
    wait_cycles = 4'(w);
    exp_dev = d;
    exp_w = w;
    exp_j = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c0 = cyc;
    mon_on = 1'b1;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      if (inject && n == inj_at) begin
        start = 1'b1;
        dev_sel = ~d;
        wait_cycles = 4'((w + 1) % 4);
      end
      if (inject && n == inj_at + 1) start = 1'b0;
      @(negedge clk);
    end
    mon_on = 1'b0;
    chk(n == 128 * (w + 1) + 1, "R2", "busy length", n, 128 * (w + 1) + 1);
    chk(exp_j == 64, "R5", "write count", exp_j, 64);
    chk(cyc == last_wr + 1, "R6", "busy fall after last write", cyc, last_wr + 1);
    if (inject) chk(busy == 1'b0, "R7", "start during busy ignored", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(cw_en == 1'b0, "R1", "cw_en at reset", cw_en, 0);
    chk(rom_addr == '0, "R1", "rom_addr at reset", rom_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "idle without start", busy, 0);
    run_load(4'd0, 0, 1'b0, 0);
    run_load(4'd15, 3, 1'b1, 7);
    run_load(4'd9, 1, 1'b1, 250);
    for (int i = 0; i < 6; i++) begin
      int w, at;
      logic [3:0] d;
      d  = 4'($urandom % 16);
      w  = $urandom % 4;
      at = 2 + ($urandom % (128 * (w + 1) - 4));
      run_load(d, w, 1'($urandom % 2), at);
    end
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && cw_en == 1'b0, "R7", "no restart after ignored start", busy, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule